// File: doc/BRIEF.md
# Page Status Update and Space Decoder

This block sits beside the page translation table of a two-level memory management unit. For every translated access it reads the page entry selected for that access and the direction of the access. It then does three things. It decides which of four address spaces the cycle goes to. It flags an access to a page that has no backing storage as a bus error. It keeps the per-page referenced and modified flags up to date by writing the entry back into the page table.

The write-back goes through a single write port. Software updates to page entries use the same port, and a software write always wins. Because the flags are written one cycle after the access, the block forwards in-flight values. An access that closely follows an update to the same page therefore sees the newest entry rather than a stale copy from the table.

Top module: `pgstat_unit`

## Requirements
- R1: One cycle after a valid access to a non-faulting page, exactly one bit of `space_sel` is high, and its index equals entry bits 13:12. Value 0 is local memory (bit 0), value 2 is external bus memory (bit 2) and value 3 is external bus I/O (bit 3).
- R2: Entry bits 13:12 equal to 01 mark an unimplemented local I/O page. One cycle after a valid access to such a page, `bus_err` is high and `space_sel` is zero. No flag write-back is issued for that access.
- R3: Every valid non-faulting access, read or write, sets the referenced flag (entry bit 15). The write-back appears on the port in the cycle after the strobe.
- R4: A write access (`acc_write`=1) also sets the modified flag (entry bit 14). A read access never sets it.
- R5: A flag write-back carries the entry with only bits ORed in. No bit of the entry, flag or otherwise, is ever cleared by hardware.
- R6: When every flag an access would set is already set in the entry, no write-back is issued.
- R7: A software write (`sw_valid`) drives the write port in its own cycle with its index and data unchanged. A hardware flag update that falls in the same cycle is discarded.
- R8: An access uses the newest entry value. If a software write targets the same page in the same cycle, its data is used. Otherwise, if a live flag update to the same page is on the port in that cycle, the updated value is used. This holds for both space decoding and flag merging.
- R9: In the cycle after a cycle with no valid access, `space_sel` is zero and `bus_err` is low. A hardware write-back follows only a valid access.
- R10: During and right after reset, `space_sel`, `bus_err` and, with no software write present, `wb_en` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | A translated access uses the selected entry this cycle |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| acc_idx | input | IDX_W | Page table index of the access |
| acc_entry | input | 16 | Page entry read from the table at `acc_idx` |
| sw_valid | input | 1 | Software writes a page entry this cycle |
| sw_idx | input | IDX_W | Page table index of the software write |
| sw_data | input | 16 | Entry value written by software |
| space_sel | output | 4 | One-hot target space, indexed by mode value |
| bus_err | output | 1 | Access hit a non-existent page |
| wb_en | output | 1 | Page table write enable |
| wb_idx | output | IDX_W | Page table write index |
| wb_data | output | 16 | Page table write data |

## Verification
The bench plays the page table and keeps its own copy of every entry. It runs reads and writes over pages of all four mode values, which separates correct space decoding from faulting behaviour and shows that a modified flag comes only from writes. Repeated accesses to pages whose flags are already set show that redundant write-backs are suppressed. Entries preloaded with data and flag bits show that write-back only ORs bits in. Back-to-back accesses to the same page, software writes that collide with a pending update, and software writes that change a page's mode in the same cycle as an access separate correct forwarding and priority from the use of a stale entry.

// File: rtl/pgstat_pkg.sv
package pgstat_pkg;
    localparam int ENTRY_W   = 16;
    localparam int USED_BIT  = 15;
    localparam int DIRTY_BIT = 14;
    localparam int MODE_LO   = 12;
    localparam int MODE_W    = 2;
    localparam int NSPACE    = 1 << MODE_W;

    typedef enum logic [MODE_W-1:0] {
        SP_LOCAL_MEM = 2'b00,
        SP_LOCAL_IO  = 2'b01,
        SP_BUS_MEM   = 2'b10,
        SP_BUS_IO    = 2'b11
    } space_e;

    localparam logic [ENTRY_W-1:0] USED_MASK  = ENTRY_W'(1) << USED_BIT;
    localparam logic [ENTRY_W-1:0] DIRTY_MASK = ENTRY_W'(1) << DIRTY_BIT;
endpackage

// File: rtl/pgstat_space_dec.sv
module pgstat_space_dec
    import pgstat_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output logic [NSPACE-1:0] onehot,
    output logic              fault
);
    for (genvar k = 0; k < NSPACE; k++) begin : g_sel
        assign onehot[k] = (mode == MODE_W'(k));
    end

    // Local I/O is not present: treat it as a missing page.
    assign fault = (space_e'(mode) == SP_LOCAL_IO);
endmodule

// File: rtl/pgstat_fwd.sv
module pgstat_fwd
    import pgstat_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic [IDX_W-1:0]   acc_idx,
    input  logic [ENTRY_W-1:0] acc_entry,
    input  logic               sw_valid,
    input  logic [IDX_W-1:0]   sw_idx,
    input  logic [ENTRY_W-1:0] sw_data,
    input  logic               pend_live,
    input  logic [IDX_W-1:0]   pend_idx,
    input  logic [ENTRY_W-1:0] pend_data,
    output logic [ENTRY_W-1:0] base
);
    always_comb begin
        if (sw_valid && sw_idx == acc_idx) begin
            base = sw_data;
        end else if (pend_live && pend_idx == acc_idx) begin
            base = pend_data;
        end else begin
            base = acc_entry;
        end
    end
endmodule

// File: rtl/pgstat_wb_mux.sv
module pgstat_wb_mux
    import pgstat_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic               sw_valid,
    input  logic [IDX_W-1:0]   sw_idx,
    input  logic [ENTRY_W-1:0] sw_data,
    input  logic               pend_v,
    input  logic [IDX_W-1:0]   pend_idx,
    input  logic [ENTRY_W-1:0] pend_data,
    output logic               pend_live,
    output logic               wb_en,
    output logic [IDX_W-1:0]   wb_idx,
    output logic [ENTRY_W-1:0] wb_data
);
    assign pend_live = pend_v && !sw_valid;
    assign wb_en     = sw_valid || pend_v;
    assign wb_idx    = sw_valid ? sw_idx  : pend_idx;
    assign wb_data   = sw_valid ? sw_data : pend_data;
endmodule

// File: rtl/pgstat_unit.sv
module pgstat_unit
    import pgstat_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic [IDX_W-1:0]   acc_idx,
    input  logic [15:0]        acc_entry,
    input  logic               sw_valid,
    input  logic [IDX_W-1:0]   sw_idx,
    input  logic [15:0]        sw_data,
    output logic [3:0]         space_sel,
    output logic               bus_err,
    output logic               wb_en,
    output logic [IDX_W-1:0]   wb_idx,
    output logic [15:0]        wb_data
);
    typedef struct packed {
        logic [NSPACE-1:0]  sel;
        logic               berr;
        logic               pend_v;
        logic [IDX_W-1:0]   pend_idx;
        logic [ENTRY_W-1:0] pend_data;
    } state_t;

    state_t st_d, st_q;

    logic               pend_live;
    logic [ENTRY_W-1:0] base;
    logic [NSPACE-1:0]  onehot;
    logic               fault;
    logic [ENTRY_W-1:0] flags;
    logic [ENTRY_W-1:0] merged;

    pgstat_wb_mux #(.IDX_W(IDX_W)) u_wb (
        .sw_valid (sw_valid),
        .sw_idx   (sw_idx),
        .sw_data  (sw_data),
        .pend_v   (st_q.pend_v),
        .pend_idx (st_q.pend_idx),
        .pend_data(st_q.pend_data),
        .pend_live(pend_live),
        .wb_en    (wb_en),
        .wb_idx   (wb_idx),
        .wb_data  (wb_data)
    );

    pgstat_fwd #(.IDX_W(IDX_W)) u_fwd (
        .acc_idx  (acc_idx),
        .acc_entry(acc_entry),
        .sw_valid (sw_valid),
        .sw_idx   (sw_idx),
        .sw_data  (sw_data),
        .pend_live(pend_live),
        .pend_idx (st_q.pend_idx),
        .pend_data(st_q.pend_data),
        .base     (base)
    );

    pgstat_space_dec u_dec (
        .mode  (base[MODE_LO +: MODE_W]),
        .onehot(onehot),
        .fault (fault)
    );

    always_comb begin
        flags  = USED_MASK | (acc_write ? DIRTY_MASK : '0);
        merged = base | flags;

        st_d           = st_q;
        st_d.sel       = (acc_valid && !fault) ? onehot : '0;
        st_d.berr      = acc_valid && fault;
        st_d.pend_v    = acc_valid && !fault && (merged != base);
        st_d.pend_idx  = acc_idx;
        st_d.pend_data = merged;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign space_sel = st_q.sel;
    assign bus_err   = st_q.berr;
endmodule

// File: rtl/pgstat_unit_chk.sv
module pgstat_unit_chk #(
    parameter int IDX_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_valid,
    input logic             sw_valid,
    input logic [IDX_W-1:0] sw_idx,
    input logic [15:0]      sw_data,
    input logic [3:0]       space_sel,
    input logic             bus_err,
    input logic             wb_en,
    input logic [IDX_W-1:0] wb_idx,
    input logic [15:0]      wb_data
);
    assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(space_sel));

    assert_access_target_R1: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> (bus_err || $countones(space_sel) == 1));

    assert_fault_no_sel_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> space_sel == 4'b0000);

    assert_fault_no_update_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_err && !sw_valid) |-> !wb_en);

    assert_hw_update_used_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && !sw_valid) |-> wb_data[15]);

    assert_sw_priority_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sw_valid |-> (wb_en && wb_idx == sw_idx && wb_data == sw_data));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (space_sel == 4'b0000 && !bus_err));

    assert_update_needs_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_en && !sw_valid) |-> $past(acc_valid));
endmodule

bind pgstat_unit pgstat_unit_chk #(.IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_valid(acc_valid),
    .sw_valid (sw_valid),
    .sw_idx   (sw_idx),
    .sw_data  (sw_data),
    .space_sel(space_sel),
    .bus_err  (bus_err),
    .wb_en    (wb_en),
    .wb_idx   (wb_idx),
    .wb_data  (wb_data)
);

// File: tb/pgstat_unit_test.sv
`timescale 1ns/1ps
module pgstat_unit_test;
    localparam int IW = 10;
    localparam int NP = 1 << IW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic          acc_write = 1'b0;
    logic [IW-1:0] acc_idx = '0;
    logic [15:0]   acc_entry;
    logic          sw_valid = 1'b0;
    logic [IW-1:0] sw_idx = '0;
    logic [15:0]   sw_data = '0;
    logic [3:0]    space_sel;
    logic          bus_err;
    logic          wb_en;
    logic [IW-1:0] wb_idx;
    logic [15:0]   wb_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // Page table played by the bench, plus an independent expected copy
    logic [15:0] ptab [NP];
    logic [15:0] shadow [NP];

    typedef struct packed {
        logic [3:0]    sel;
        logic          berr;
        logic          wen;
        logic [IW-1:0] widx;
        logic [15:0]   wdata;
    } exp_t;
    exp_t  expq[$];
    string tagq[$];

    // Model state for the access of the previous step
    logic [3:0]    m_sel = '0;
    logic          m_berr = 1'b0;
    logic          m_pv = 1'b0;
    logic [IW-1:0] m_pi = '0;
    logic [15:0]   m_pbits = '0;

    always #4 clk = ~clk;

    pgstat_unit #(.IDX_W(IW)) uut (
        .clk(clk), .rst_n(rst_n),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_idx(acc_idx),
        .acc_entry(acc_entry),
        .sw_valid(sw_valid), .sw_idx(sw_idx), .sw_data(sw_data),
        .space_sel(space_sel), .bus_err(bus_err),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
    );

    assign acc_entry = ptab[acc_idx];

    always @(posedge clk) begin
        if (wb_en) ptab[wb_idx] <= wb_data;
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // Driver: one clock step, pushes the expected outputs for this cycle
    task automatic step(input bit av, input bit aw, input int ai,
                        input bit sv, input int si, input logic [15:0] sd,
                        input string tag);
        exp_t e;
        logic [1:0]  mode;
        logic [15:0] bits;
        @(posedge clk);
        #1;
        acc_valid = av; acc_write = aw; acc_idx = IW'(ai);
        sw_valid = sv; sw_idx = IW'(si); sw_data = sd;
        e = '0;
        e.sel  = m_sel;
        e.berr = m_berr;
        if (sv) begin
            // R7: software write owns the port; pending update dropped
            shadow[si] = sd;
            e.wen = 1'b1; e.widx = IW'(si); e.wdata = sd;
        end else if (m_pv) begin
            shadow[m_pi] = shadow[m_pi] | m_pbits;
            e.wen = 1'b1; e.widx = m_pi; e.wdata = shadow[m_pi];
        end
        if (av) begin
            mode = shadow[ai][13:12];
            if (mode == 2'b01) begin
                m_sel = '0; m_berr = 1'b1; m_pv = 1'b0;
            end else begin
                m_sel = 4'(1) << mode; m_berr = 1'b0;
                bits = 16'h8000 | (aw ? 16'h4000 : 16'h0000);
                m_pv = (bits & ~shadow[ai]) != 16'h0;
                m_pi = IW'(ai); m_pbits = bits;
            end
        end else begin
            m_sel = '0; m_berr = 1'b0; m_pv = 1'b0;
        end
        expq.push_back(e);
        tagq.push_back(tag);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 16'h0, "R9");
    endtask

    // Monitor: compares at the falling edge
    always @(negedge clk) begin
        if (expq.size() > 0) begin
            exp_t e;
            string t;
            e = expq.pop_front();
            t = tagq.pop_front();
            chk(space_sel == e.sel, {t, "/R1"}, "space_sel", 32'(space_sel), 32'(e.sel));
            chk(bus_err == e.berr, {t, "/R2"}, "bus_err", 32'(bus_err), 32'(e.berr));
            chk(wb_en == e.wen, t, "wb_en", 32'(wb_en), 32'(e.wen));
            if (e.wen && wb_en) begin
                chk(wb_idx == e.widx, t, "wb_idx", 32'(wb_idx), 32'(e.widx));
                chk(wb_data == e.wdata, t, "wb_data", 32'(wb_data), 32'(e.wdata));
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // Page i starts with mode i%4, flags clear, address bits = i
        for (int i = 0; i < NP; i++) begin
            ptab[i]   = 16'(((i % 4) << 12) | (i & 12'hfff));
            shadow[i] = ptab[i];
        end
        repeat (3) @(posedge clk);
        #2;
        // R10: reset state
        chk(space_sel == 4'b0 && !bus_err && !wb_en, "R10", "reset outputs",
            {26'b0, space_sel, bus_err, wb_en}, 32'h0);
        @(posedge clk); #1; rst_n = 1'b1;
        @(negedge clk);
        chk(space_sel == 4'b0 && !bus_err && !wb_en, "R10", "after reset",
            {26'b0, space_sel, bus_err, wb_en}, 32'h0);

        // R1 R3: reads over local mem, bus mem, bus I/O
        step(1, 0, 0, 0, 0, 16'h0, "R3");
        step(1, 0, 2, 0, 0, 16'h0, "R3");
        step(1, 0, 3, 0, 0, 16'h0, "R3");
        idle(2);
        // R4: write sets modified as well
        step(1, 1, 4, 0, 0, 16'h0, "R4");
        idle(2);
        // R2: missing page, read then write
        step(1, 0, 1, 0, 0, 16'h0, "R2");
        step(1, 1, 5, 0, 0, 16'h0, "R2");
        idle(2);
        // R6: flags already present -> no write-back; new dirty -> write-back
        step(1, 0, 0, 0, 0, 16'h0, "R6");
        idle(1);
        step(1, 1, 0, 0, 0, 16'h0, "R6");
        idle(1);
        step(1, 1, 0, 0, 0, 16'h0, "R6");
        idle(2);
        // R5: preloaded data and modified bit are kept
        step(0, 0, 0, 1, 12, 16'h4ABC, "R5");
        idle(1);
        step(1, 0, 12, 0, 0, 16'h0, "R5");
        idle(2);
        // R8: back-to-back accesses to the same page
        step(1, 0, 8, 0, 0, 16'h0, "R8");
        step(1, 1, 8, 0, 0, 16'h0, "R8");
        step(1, 0, 8, 0, 0, 16'h0, "R8");
        idle(2);
        // R7: software write collides with a pending update of another page
        step(1, 1, 16, 0, 0, 16'h0, "R7");
        step(0, 0, 0, 1, 20, 16'h2555, "R7");
        idle(2);
        // R7: collision on the same page
        step(1, 0, 28, 0, 0, 16'h0, "R7");
        step(0, 0, 0, 1, 28, 16'h3001, "R7");
        idle(2);
        // R8: software write changes mode in the same cycle as the access
        step(1, 1, 24, 1, 24, 16'h1024, "R8");
        idle(1);
        step(1, 0, 32, 1, 32, 16'h3777, "R8");
        idle(2);
        // Mixed traffic over many pages
        for (int i = 0; i < 200; i++) begin
            int pg;
            pg = 40 + (i * 7) % 64;
            step(1, (i % 3) == 0, pg, (i % 11) == 5, 40 + (i * 13) % 64,
                 16'((i * 16'h1357) & 16'h3fff), "R5");
            if ((i % 9) == 0) idle(1);
        end
        idle(3);
        @(negedge clk);
        // R5: table contents match the expected copy
        for (int i = 0; i < NP; i++) begin
            chk(ptab[i] == shadow[i], "R5", $sformatf("entry %0d", i),
                32'(ptab[i]), 32'(shadow[i]));
        end
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule